// File: doc/BRIEF.md
# Shift-Up Event Queue with Count and Overflow

This block collects byte-wide events from three producers (a key scanner, a general-purpose input detector and a logic-function source) and keeps up to sixteen of them for a host to read over a register interface. Each byte carries a 7-bit event identifier in bits [6:0] and a state flag in bit 7 (1 = pressed or active, 0 = released or inactive). The oldest event always sits at the head. A read strobe, which the register decoder raises for any of the queue's read addresses, returns the head and pops it, so every remaining entry moves up one place.

New events first enter a four-entry holding queue, which takes the three producers in a fixed priority order when they fire together. A small controller moves one held event per cycle into the main store. It stops while the host bus is touching the queue addresses (`bus_hold`), so the store stays stable during a transaction, and it resumes when the transaction ends. The controller has three states. ST_OPEN means no hold and nothing waiting. ST_MOVE means no hold and at least one event waiting, and it transfers one per cycle. ST_HOLD means the bus holds the store. From any state the next state is ST_HOLD when `bus_hold` is high. Otherwise it is ST_MOVE when the holding queue will contain anything after the current edge, and ST_OPEN when it will not. The block keeps an event count, a sticky overflow flag with a maskable overflow interrupt, and an event interrupt request.

Top module: `evq_fifo`

## Requirements
- R1: Each stored byte is kept unchanged, with the identifier in bits [6:0] and the state in bit 7. Up to 16 bytes are held.
- R2: `ev_count` ranges from 0 to 16. It goes up by one for each stored event and down by one for each pop of a non-empty store.
- R3: `rd_data` always shows the oldest stored event. A cycle with `rd_pop` high removes it and moves the others up, so events leave in arrival order.
- R4: While the store is empty, `rd_data` is 0x00, and a pop leaves the count at 0.
- R5: An event that reaches a full store (with no pop in the same cycle) is discarded, the stored contents stay unchanged, and `ovf_flag` is set. The flag stays set until a cycle with `ovf_clr` high. A new overflow in that same cycle keeps it set.
- R6: `ovf_irq` is high exactly when `ovf_flag` is set and `ovf_irq_en` is high.
- R7: While `bus_hold` is high, nothing is written to the store, although pops still work. Events that arrive during the hold are kept in the holding queue and are stored in arrival order, one per cycle, once the hold ends.
- R8: Events from the producers in the same cycle are queued in the order key, then GPI, then logic.
- R9: An event that finds the four-entry holding queue full is discarded and sets `ovf_flag`.
- R10: Every stored event sets `ev_irq`. `ev_irq_clr` clears it, and a store in the same cycle wins over the clear.
- R11: With no hold and an empty holding queue, an event presented in one cycle becomes visible in `ev_count`, `rd_data` and `ev_irq` after the second following rising clock edge.
- R12: A pop and a store in the same cycle both take effect. On a full store this means the new event is accepted without overflow and lands at the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_vld | input | 1 | Key scanner event valid |
| key_code | input | 8 | Key scanner event byte |
| gpi_vld | input | 1 | GPI detector event valid |
| gpi_code | input | 8 | GPI detector event byte |
| lgc_vld | input | 1 | Logic source event valid |
| lgc_code | input | 8 | Logic source event byte |
| bus_hold | input | 1 | Host transaction on the queue addresses in progress |
| rd_pop | input | 1 | Read strobe for any queue address; pops the head |
| rd_data | output | 8 | Head event, 0x00 when empty |
| ev_count | output | 5 | Number of stored events |
| ovf_clr | input | 1 | Write-one-to-clear of the overflow flag |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| ovf_flag | output | 1 | Sticky overflow status |
| ovf_irq | output | 1 | Overflow interrupt request |
| ev_irq_clr | input | 1 | Clear of the event interrupt |
| ev_irq | output | 1 | Event interrupt request |

## Verification
The hardest state to reach is a full holding queue. Events only pile up there while the store is held, and even then at most three can arrive per cycle, so the bench raises `bus_hold` and fires all three producers in two back-to-back cycles. That drops the last two events of the second burst. The other corner is a pop that lands in the same cycle as a store into a full store. The bench reaches it by filling all sixteen slots, posting one more event, and raising `rd_pop` exactly in the cycle the controller transfers that event.

// File: rtl/evq_pkg.sv
package evq_pkg;
    typedef enum logic [1:0] {
        ST_OPEN = 2'd0,
        ST_MOVE = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;

    localparam int SRC_KEY = 0;
    localparam int SRC_GPI = 1;
    localparam int SRC_LGC = 2;
    localparam int NUM_SRC = 3;
endpackage

// File: rtl/evq_intake.sv
module evq_intake #(
    parameter int W    = 8,
    parameter int QD   = 4,
    parameter int NSRC = 3,
    localparam int QCW = $clog2(QD + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           src_vld,
    input  logic [NSRC-1:0][W-1:0]    src_code,
    input  logic                      pop,
    output logic [W-1:0]              head,
    output logic [QCW-1:0]            q_cnt,
    output logic [QCW-1:0]            q_cnt_nxt,
    output logic                      drop
);
    logic [QD-1:0][W-1:0] q_mem;
    logic [QD-1:0][W-1:0] q_work;

    always_comb begin
        q_work    = q_mem;
        q_cnt_nxt = q_cnt;
        drop      = 1'b0;
        if (pop && q_cnt != '0) begin
            for (int j = 0; j < QD - 1; j++) begin
                q_work[j] = q_mem[j+1];
            end
            q_work[QD-1] = '0;
            q_cnt_nxt    = q_cnt - QCW'(1);
        end
        // lower source index has higher priority
        for (int s = 0; s < NSRC; s++) begin
            if (src_vld[s]) begin
                if (q_cnt_nxt < QCW'(QD)) begin
                    for (int j = 0; j < QD; j++) begin
                        if (QCW'(j) == q_cnt_nxt) begin
                            q_work[j] = src_code[s];
                        end
                    end
                    q_cnt_nxt = q_cnt_nxt + QCW'(1);
                end else begin
                    drop = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_mem <= '0;
            q_cnt <= '0;
        end else begin
            q_mem <= q_work;
            q_cnt <= q_cnt_nxt;
        end
    end

    assign head = q_mem[0];
endmodule

// File: rtl/evq_seq.sv
module evq_seq
    import evq_pkg::*;
#(
    parameter int QCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_hold,
    input  logic [QCW-1:0] q_cnt_nxt,
    output logic           xfer
);
    seq_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OPEN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OPEN: begin
                if (bus_hold)               state_nxt = ST_HOLD;
                else if (q_cnt_nxt != '0)   state_nxt = ST_MOVE;
            end
            ST_MOVE: begin
                if (bus_hold)               state_nxt = ST_HOLD;
                else if (q_cnt_nxt == '0)   state_nxt = ST_OPEN;
            end
            ST_HOLD: begin
                if (!bus_hold) begin
                    state_nxt = (q_cnt_nxt != '0) ? ST_MOVE : ST_OPEN;
                end
            end
            default: state_nxt = ST_OPEN;
        endcase
    end

    always_comb begin
        xfer = 1'b0;
        unique case (state)
            ST_OPEN: xfer = 1'b0;
            ST_MOVE: xfer = !bus_hold;
            ST_HOLD: xfer = 1'b0;
            default: xfer = 1'b0;
        endcase
    end
endmodule

// File: rtl/evq_shelf.sv
module evq_shelf #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_pop,
    input  logic          lost_in,
    input  logic          ovf_clr,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          stored,
    output logic          ovf_flag
);
    logic [DEPTH-1:0][W-1:0] slot;
    logic pop_eff;
    logic wr_ok;

    assign pop_eff = rd_pop && (count != '0);
    assign wr_ok   = wr_req && ((count < CW'(DEPTH)) || pop_eff);
    assign stored  = wr_ok;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [W-1:0] above;
        if (i < DEPTH - 1) begin : g_mid
            assign above = slot[i+1];
        end else begin : g_top
            assign above = '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (pop_eff) begin
                if (wr_ok && (CW'(i + 1) == count)) begin
                    slot[i] <= wr_data;
                end else begin
                    slot[i] <= above;
                end
            end else if (wr_ok && (CW'(i) == count)) begin
                slot[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            count <= count + CW'(wr_ok) - CW'(pop_eff);
            if ((wr_req && !wr_ok) || lost_in) begin
                ovf_flag <= 1'b1;
            end else if (ovf_clr) begin
                ovf_flag <= 1'b0;
            end
        end
    end

    assign head = (count == '0) ? '0 : slot[0];
endmodule

// File: rtl/evq_fifo.sv
module evq_fifo
    import evq_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int QD    = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int QCW  = $clog2(QD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_vld,
    input  logic [W-1:0]  key_code,
    input  logic          gpi_vld,
    input  logic [W-1:0]  gpi_code,
    input  logic          lgc_vld,
    input  logic [W-1:0]  lgc_code,
    input  logic          bus_hold,
    input  logic          rd_pop,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] ev_count,
    input  logic          ovf_clr,
    input  logic          ovf_irq_en,
    output logic          ovf_flag,
    output logic          ovf_irq,
    input  logic          ev_irq_clr,
    output logic          ev_irq
);
    logic [NUM_SRC-1:0]        src_vld;
    logic [NUM_SRC-1:0][W-1:0] src_code;
    logic [W-1:0]              q_head;
    logic [QCW-1:0]            q_cnt;
    logic [QCW-1:0]            q_cnt_nxt;
    logic                      q_drop;
    logic                      xfer;
    logic                      stored;

    always_comb begin
        src_vld           = '0;
        src_code          = '0;
        src_vld[SRC_KEY]  = key_vld;
        src_code[SRC_KEY] = key_code;
        src_vld[SRC_GPI]  = gpi_vld;
        src_code[SRC_GPI] = gpi_code;
        src_vld[SRC_LGC]  = lgc_vld;
        src_code[SRC_LGC] = lgc_code;
    end

    evq_intake #(.W(W), .QD(QD), .NSRC(NUM_SRC)) u_intake (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_vld   (src_vld),
        .src_code  (src_code),
        .pop       (xfer),
        .head      (q_head),
        .q_cnt     (q_cnt),
        .q_cnt_nxt (q_cnt_nxt),
        .drop      (q_drop)
    );

    evq_seq #(.QCW(QCW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_hold  (bus_hold),
        .q_cnt_nxt (q_cnt_nxt),
        .xfer      (xfer)
    );

    evq_shelf #(.W(W), .DEPTH(DEPTH)) u_shelf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (xfer),
        .wr_data  (q_head),
        .rd_pop   (rd_pop),
        .lost_in  (q_drop),
        .ovf_clr  (ovf_clr),
        .head     (rd_data),
        .count    (ev_count),
        .stored   (stored),
        .ovf_flag (ovf_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_irq <= 1'b0;
        end else if (stored) begin
            ev_irq <= 1'b1;
        end else if (ev_irq_clr) begin
            ev_irq <= 1'b0;
        end
    end

    assign ovf_irq = ovf_flag && ovf_irq_en;
endmodule

// File: rtl/evq_fifo_chk.sv
module evq_fifo_chk #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_hold,
    input logic          rd_pop,
    input logic [W-1:0]  rd_data,
    input logic [CW-1:0] ev_count,
    input logic          ovf_clr,
    input logic          ovf_flag,
    input logic          ev_irq
);
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        ev_count <= CW'(DEPTH));

    a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_count == '0) |-> (rd_data == '0));

    a_r7_hold_no_store: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (bus_hold && !rd_pop) |=> (ev_count == $past(ev_count)));

    a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (bus_hold && rd_pop && ev_count != '0) |=> (ev_count == $past(ev_count) - CW'(1)));

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    a_r10_irq_on_store: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (ev_count > $past(ev_count)) |-> ev_irq);
endmodule

bind evq_fifo evq_fifo_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_hold (bus_hold),
    .rd_pop   (rd_pop),
    .rd_data  (rd_data),
    .ev_count (ev_count),
    .ovf_clr  (ovf_clr),
    .ovf_flag (ovf_flag),
    .ev_irq   (ev_irq)
);

// File: tb/evq_fifo_test.sv
module evq_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_vld = 1'b0, gpi_vld = 1'b0, lgc_vld = 1'b0;
    logic [7:0] key_code = '0, gpi_code = '0, lgc_code = '0;
    logic       bus_hold = 1'b0, rd_pop = 1'b0;
    logic       ovf_clr = 1'b0, ovf_irq_en = 1'b0, ev_irq_clr = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] ev_count;
    logic       ovf_flag, ovf_irq, ev_irq;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evq_fifo uut (
        .clk(clk), .rst_n(rst_n),
        .key_vld(key_vld), .key_code(key_code),
        .gpi_vld(gpi_vld), .gpi_code(gpi_code),
        .lgc_vld(lgc_vld), .lgc_code(lgc_code),
        .bus_hold(bus_hold), .rd_pop(rd_pop),
        .rd_data(rd_data), .ev_count(ev_count),
        .ovf_clr(ovf_clr), .ovf_irq_en(ovf_irq_en),
        .ovf_flag(ovf_flag), .ovf_irq(ovf_irq),
        .ev_irq_clr(ev_irq_clr), .ev_irq(ev_irq)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic post_key(logic [7:0] c);
        key_vld = 1'b1; key_code = c;
        tick();
        key_vld = 1'b0;
    endtask

    // pop once, checking head value before the pop
    task automatic pop_expect(string req, logic [7:0] exp);
        chk(req, rd_data, exp);
        rd_pop = 1'b1;
        tick();
        rd_pop = 1'b0;
    endtask

    task automatic t_reset;
        chk("R2 reset count", ev_count, 0);
        chk("R4 reset data", rd_data, 0);
        chk("R5 reset ovf", ovf_flag, 0);
        chk("R10 reset irq", ev_irq, 0);
    endtask

    task automatic t_single;
        post_key(8'hA0);
        chk("R11 not yet counted", ev_count, 0);
        tick();
        chk("R11 count after two edges", ev_count, 1);
        chk("R1 stored byte", rd_data, 8'hA0);
        chk("R10 irq set", ev_irq, 1);
        ev_irq_clr = 1'b1; tick(); ev_irq_clr = 1'b0;
        chk("R10 irq cleared", ev_irq, 0);
        pop_expect("R3 single pop", 8'hA0);
        chk("R2 count back to 0", ev_count, 0);
    endtask

    task automatic t_order;
        post_key(8'h81); post_key(8'h05); post_key(8'hE2);
        tick(3);
        chk("R2 count three", ev_count, 3);
        pop_expect("R3 order first", 8'h81);
        chk("R2 decrement", ev_count, 2);
        pop_expect("R3 order second", 8'h05);
        pop_expect("R3 order third", 8'hE2);
        chk("R2 drained", ev_count, 0);
    endtask

    task automatic t_empty;
        rd_pop = 1'b1; tick(); rd_pop = 1'b0;
        chk("R4 empty data", rd_data, 0);
        chk("R4 empty count", ev_count, 0);
    endtask

    task automatic t_priority;
        lgc_vld = 1'b1; lgc_code = 8'hF3;
        gpi_vld = 1'b1; gpi_code = 8'hE1;
        key_vld = 1'b1; key_code = 8'h90;
        tick();
        {key_vld, gpi_vld, lgc_vld} = 3'b000;
        tick(5);
        chk("R8 count", ev_count, 3);
        pop_expect("R8 key first", 8'h90);
        pop_expect("R8 gpi second", 8'hE1);
        pop_expect("R8 logic third", 8'hF3);
    endtask

    task automatic t_hold;
        bus_hold = 1'b1;
        post_key(8'h11); post_key(8'h92);
        tick(3);
        chk("R7 no store during hold", ev_count, 0);
        bus_hold = 1'b0;
        tick(4);
        chk("R7 stored after hold", ev_count, 2);
        bus_hold = 1'b1;
        pop_expect("R7 first after hold", 8'h11);
        pop_expect("R7 second after hold", 8'h92);
        bus_hold = 1'b0;
        chk("R7 pop during hold", ev_count, 0);
    endtask

    task automatic t_qfull;
        bus_hold = 1'b1;
        key_vld = 1'b1; key_code = 8'h21; gpi_vld = 1'b1; gpi_code = 8'hE2; lgc_vld = 1'b1; lgc_code = 8'hF4;
        tick();
        key_code = 8'h22; gpi_code = 8'hE3; lgc_code = 8'hF5;
        tick();
        {key_vld, gpi_vld, lgc_vld} = 3'b000;
        chk("R9 queue drop sets ovf", ovf_flag, 1);
        bus_hold = 1'b0;
        tick(6);
        chk("R9 four kept", ev_count, 4);
        pop_expect("R9 kept 1", 8'h21);
        pop_expect("R9 kept 2", 8'hE2);
        pop_expect("R9 kept 3", 8'hF4);
        pop_expect("R9 kept 4", 8'h22);
        chk("R9 drained", ev_count, 0);
        ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
        chk("R5 ovf cleared", ovf_flag, 0);
    endtask

    task automatic t_full;
        for (int i = 0; i < 17; i++) post_key({i[0], 7'(i + 1)});
        tick(4);
        chk("R2 full count", ev_count, 16);
        chk("R5 ovf set", ovf_flag, 1);
        chk("R6 irq masked", ovf_irq, 0);
        ovf_irq_en = 1'b1; tick();
        chk("R6 irq enabled", ovf_irq, 1);
        tick(3);
        chk("R5 ovf sticky", ovf_flag, 1);
        ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
        chk("R5 ovf w1c", ovf_flag, 0);
        chk("R6 irq follows flag", ovf_irq, 0);
        for (int i = 0; i < 16; i++) pop_expect("R5 contents unchanged", {i[0], 7'(i + 1)});
        chk("R5 17th discarded", ev_count, 0);
        ovf_irq_en = 1'b0;
    endtask

    task automatic t_pop_write;
        for (int i = 0; i < 16; i++) post_key(8'h40 + 8'(i));
        tick(4);
        chk("R12 prefilled", ev_count, 16);
        key_vld = 1'b1; key_code = 8'h7E;
        tick();
        key_vld = 1'b0;
        pop_expect("R12 head before", 8'h40);
        chk("R12 count unchanged", ev_count, 16);
        chk("R12 no overflow", ovf_flag, 0);
        for (int i = 1; i < 16; i++) pop_expect("R12 shifted", 8'h40 + 8'(i));
        pop_expect("R12 tail new", 8'h7E);
        chk("R12 drained", ev_count, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_single();
        t_order();
        t_empty();
        t_priority();
        t_hold();
        t_qfull();
        t_full();
        t_pop_write();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule